// File: doc/BRIEF.md
# Sync-Value Clamp and Luma/Chroma Word Interleaver

This block sits at the front of a high-definition serial video transmit path. At each word slot it takes a 20-bit pair made of a luma word and a chroma word. Both words are registered. Any word whose top eight bits are all zeros or all ones has its two low bits forced to zeros or to ones. An 8-bit source, whose two low bits are undefined, then still yields the exact 10-bit timing-reference codes 0x000 and 0x3FF. The pair is then sent out as a 10-bit stream at twice the word rate, chroma first and luma second, ready for a scrambler.

The whole block runs on one clock at the serial-word rate (twice the pair rate). `word_en` marks the cycles that act as parallel-clock edges, and it must be high on every other cycle. A mapping-disable input, sampled together with each pair, lets non-video payloads pass through bit-exact. A synchronous active-high reset empties the pipeline.

Top module: `yc_sync_interleave`

## Requirements
- R1: On a rising `clk` edge with `word_en` high, `pair_in[9:0]` is taken as the chroma word and `pair_in[19:10]` as the luma word. The chroma word of a pair is emitted on `word_out` before its luma word.
- R2: With mapping enabled, a word whose bits [9:2] are all zero (values 0x000 to 0x003) is emitted as 0x000.
- R3: With mapping enabled, a word whose bits [9:2] are all one (values 0x3FC to 0x3FF) is emitted as 0x3FF.
- R4: Any word whose bits [9:2] are neither all zero nor all one is emitted unchanged, for example 0x004, 0x3FB and 0x0FF.
- R5: When `map_off` is high at the capture edge, both words of that pair are emitted unchanged, whatever their value. The value of `map_off` on other cycles has no effect on that pair.
- R6: The chroma word captured at the `word_en` edge E appears on `word_out` after edge E+4, which is the second following `word_en` edge. Its luma word appears after edge E+5.
- R7: `out_valid` is low after reset until the first captured pair reaches the output. From then on it stays high in both phases.
- R8: While reset is applied, and until the first pair captured after reset reaches the output, `word_out` reads 0x000 and `out_valid` reads 0.
- R9: `out_is_luma` is 0 after an edge with `word_en` high and 1 after an edge with `word_en` low. It marks which word of the pair `word_out` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-word clock, twice the pair rate |
| rst | input | 1 | Synchronous active-high reset |
| word_en | input | 1 | Pair-rate enable, high on every other cycle |
| map_off | input | 1 | High disables sync-value mapping for the pair being captured |
| pair_in | input | 20 | Luma in [19:10], chroma in [9:0] |
| word_out | output | 10 | Interleaved 10-bit word stream |
| out_valid | output | 1 | Output carries captured data |
| out_is_luma | output | 1 | 0 for the chroma word, 1 for the luma word |

## Verification
The bench builds the block with its default parameters: 10-bit words, two forced low bits and two lanes. Every mapping boundary is therefore an explicit 10-bit code. The vectors sit on both sides of each clamp edge: 0x003 against 0x004, and 0x3FB against 0x3FC. A continuous stream of pairs checks the two-slot alignment of chroma and luma against the input order. A toggled disable input and a reset in mid-stream check bypass and the return to the zero output.

// File: rtl/yc_pkg.sv
package yc_pkg;
  localparam int YC_WORD_W  = 10;
  localparam int YC_FORCE_W = 2;
  localparam int YC_LANES   = 2;
endpackage

// File: rtl/yc_word_clamp.sv
module yc_word_clamp #(
  parameter int WORD_W  = yc_pkg::YC_WORD_W,
  parameter int FORCE_W = yc_pkg::YC_FORCE_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              bypass_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int UP_W = WORD_W - FORCE_W;

  logic [UP_W-1:0] upper;
  assign upper = word_i[WORD_W-1:FORCE_W];

  always_comb begin
    word_o = word_i;
    if (!bypass_i) begin
      if (upper == '0)      word_o[FORCE_W-1:0] = '0;
      else if (&upper)      word_o[FORCE_W-1:0] = '1;
    end
  end
endmodule

// File: rtl/yc_capture_stage.sv
module yc_capture_stage #(
  parameter int WORD_W = yc_pkg::YC_WORD_W,
  parameter int LANES  = yc_pkg::YC_LANES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    off_i,
  input  logic [LANES*WORD_W-1:0] data_i,
  output logic [LANES*WORD_W-1:0] data_o,
  output logic                    off_o,
  output logic                    vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      off_o  <= 1'b0;
      vld_o  <= 1'b0;
    end else if (en) begin
      data_o <= data_i;
      off_o  <= off_i;
      vld_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/yc_map_stage.sv
module yc_map_stage #(
  parameter int WORD_W  = yc_pkg::YC_WORD_W,
  parameter int FORCE_W = yc_pkg::YC_FORCE_W,
  parameter int LANES   = yc_pkg::YC_LANES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    off_i,
  input  logic                    vld_i,
  input  logic [LANES*WORD_W-1:0] data_i,
  output logic [LANES*WORD_W-1:0] data_o,
  output logic                    vld_o
);
  logic [LANES*WORD_W-1:0] mapped;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    yc_word_clamp #(
      .WORD_W (WORD_W),
      .FORCE_W(FORCE_W)
    ) clamp_i (
      .word_i  (data_i[g*WORD_W +: WORD_W]),
      .bypass_i(off_i),
      .word_o  (mapped[g*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else if (en) begin
      data_o <= mapped;
      vld_o  <= vld_i;
    end
  end
endmodule

// File: rtl/yc_interleave_out.sv
module yc_interleave_out #(
  parameter int WORD_W = yc_pkg::YC_WORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [2*WORD_W-1:0]   pair_i,
  input  logic                  vld_i,
  output logic [WORD_W-1:0]     word_o,
  output logic                  vld_o,
  output logic                  luma_o
);
  logic [WORD_W-1:0] luma_hold;
  logic              vld_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o    <= '0;
      vld_o     <= 1'b0;
      luma_o    <= 1'b0;
      luma_hold <= '0;
      vld_hold  <= 1'b0;
    end else if (en) begin
      word_o    <= pair_i[WORD_W-1:0];
      luma_hold <= pair_i[2*WORD_W-1:WORD_W];
      vld_o     <= vld_i;
      vld_hold  <= vld_i;
      luma_o    <= 1'b0;
    end else begin
      word_o    <= luma_hold;
      vld_o     <= vld_hold;
      luma_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/yc_sync_interleave.sv
module yc_sync_interleave #(
  parameter int WORD_W  = yc_pkg::YC_WORD_W,
  parameter int FORCE_W = yc_pkg::YC_FORCE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  word_en,
  input  logic                  map_off,
  input  logic [2*WORD_W-1:0]   pair_in,
  output logic [WORD_W-1:0]     word_out,
  output logic                  out_valid,
  output logic                  out_is_luma
);
  localparam int LANES  = 2;
  localparam int PAIR_W = LANES * WORD_W;

  logic [PAIR_W-1:0] cap_word;
  logic              cap_off;
  logic              cap_vld;
  logic [PAIR_W-1:0] map_word;
  logic              map_vld;

  yc_capture_stage #(
    .WORD_W(WORD_W),
    .LANES (LANES)
  ) cap_i (
    .clk   (clk),
    .rst   (rst),
    .en    (word_en),
    .off_i (map_off),
    .data_i(pair_in),
    .data_o(cap_word),
    .off_o (cap_off),
    .vld_o (cap_vld)
  );

  yc_map_stage #(
    .WORD_W (WORD_W),
    .FORCE_W(FORCE_W),
    .LANES  (LANES)
  ) map_i (
    .clk   (clk),
    .rst   (rst),
    .en    (word_en),
    .off_i (cap_off),
    .vld_i (cap_vld),
    .data_i(cap_word),
    .data_o(map_word),
    .vld_o (map_vld)
  );

  yc_interleave_out #(
    .WORD_W(WORD_W)
  ) out_i (
    .clk   (clk),
    .rst   (rst),
    .en    (word_en),
    .pair_i(map_word),
    .vld_i (map_vld),
    .word_o(word_out),
    .vld_o (out_valid),
    .luma_o(out_is_luma)
  );
endmodule

// File: rtl/yc_sync_interleave_chk.sv
module yc_sync_interleave_chk #(
  parameter int WORD_W  = yc_pkg::YC_WORD_W,
  parameter int FORCE_W = yc_pkg::YC_FORCE_W
) (
  input logic                clk,
  input logic                rst,
  input logic                word_en,
  input logic                out_valid,
  input logic                out_is_luma,
  input logic                cap_off,
  input logic [2*WORD_W-1:0] cap_word,
  input logic [2*WORD_W-1:0] map_word
);
  AST_CHROMA_PHASE: assert property (@(posedge clk) disable iff (rst)
    word_en |=> !out_is_luma);  // R9
  AST_LUMA_PHASE: assert property (@(posedge clk) disable iff (rst)
    !word_en |=> out_is_luma);  // R9
  AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (word_en && !cap_off && cap_word[WORD_W-1:FORCE_W] == '0)
      |=> map_word[FORCE_W-1:0] == '0);  // R2
  AST_HIGH_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (word_en && !cap_off && (&cap_word[2*WORD_W-1:WORD_W+FORCE_W]))
      |=> (&map_word[WORD_W+FORCE_W-1:WORD_W]));  // R3
  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (word_en && cap_off) |=> map_word == $past(cap_word));  // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);  // R7
endmodule

bind yc_sync_interleave yc_sync_interleave_chk #(
  .WORD_W (WORD_W),
  .FORCE_W(FORCE_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .word_en    (word_en),
  .out_valid  (out_valid),
  .out_is_luma(out_is_luma),
  .cap_off    (cap_off),
  .cap_word   (cap_word),
  .map_word   (map_word)
);

// File: tb/yc_sync_interleave_tb_top.sv
module yc_sync_interleave_tb_top;
  localparam int N = 10;
  // {off, luma_in, chroma_in, luma_exp, chroma_exp}
  localparam logic [40:0] VEC [N] = '{
    {1'b0, 10'h3FF, 10'h000, 10'h3FF, 10'h000},
    {1'b0, 10'h3FD, 10'h002, 10'h3FF, 10'h000},
    {1'b0, 10'h3FC, 10'h001, 10'h3FF, 10'h000},
    {1'b0, 10'h003, 10'h3FE, 10'h000, 10'h3FF},
    {1'b0, 10'h004, 10'h3FB, 10'h004, 10'h3FB},
    {1'b0, 10'h200, 10'h040, 10'h200, 10'h040},
    {1'b1, 10'h3FD, 10'h002, 10'h3FD, 10'h002},
    {1'b1, 10'h001, 10'h3FE, 10'h001, 10'h3FE},
    {1'b0, 10'h2AA, 10'h155, 10'h2AA, 10'h155},
    {1'b0, 10'h0FF, 10'h300, 10'h0FF, 10'h300}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_en = 1'b0;
  logic       map_off = 1'b0;
  logic [19:0] pair_in = '0;
  logic [9:0] word_out;
  logic       out_valid;
  logic       out_is_luma;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  yc_sync_interleave dut_i (
    .clk(clk), .rst(rst), .word_en(word_en), .map_off(map_off),
    .pair_in(pair_in), .word_out(word_out), .out_valid(out_valid),
    .out_is_luma(out_is_luma)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [19:0] d, input logic off);
    @(negedge clk);
    word_en = en;
    pair_in = d;
    map_off = off;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) step(1'b0, 20'h0, 1'b0);
    check("R8 reset word_out", word_out, 10'h000);
    check("R8 reset out_valid", {9'd0, out_valid}, 10'd0);
    @(negedge clk);
    rst = 1'b0;

    // stream: R1 R2 R3 R4 R5 R6 R7
    for (int s = 0; s < N + 2; s++) begin
      logic [40:0] v;
      v = (s < N) ? VEC[s] : VEC[0];
      step(1'b1, v[39:20], v[40]);
      check("R9 chroma phase flag", {9'd0, out_is_luma}, 10'd0);
      if (s >= 2) begin
        check("R1 R2 R3 R4 R5 R6 chroma word", word_out, VEC[s-2][9:0]);
        check("R7 valid chroma phase", {9'd0, out_valid}, 10'd1);
      end else begin
        check("R8 zero before first pair", word_out, 10'h000);
        check("R7 valid low before first pair", {9'd0, out_valid}, 10'd0);
      end
      // R5: disable value off the capture edge must not matter
      step(1'b0, ~v[39:20], ~v[40]);
      check("R9 luma phase flag", {9'd0, out_is_luma}, 10'd1);
      if (s >= 2) begin
        check("R1 R2 R3 R4 R5 R6 luma word", word_out, VEC[s-2][19:10]);
        check("R7 valid luma phase", {9'd0, out_valid}, 10'd1);
      end else begin
        check("R8 zero before first pair luma", word_out, 10'h000);
      end
    end

    // mid-stream reset
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, {10'h3FD, 10'h155}, 1'b0);
    step(1'b0, 20'h0, 1'b0);
    check("R8 mid reset word_out", word_out, 10'h000);
    check("R8 mid reset out_valid", {9'd0, out_valid}, 10'd0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, {10'h3FE, 10'h003}, 1'b0);
    check("R8 zero after reset", word_out, 10'h000);
    step(1'b0, 20'h0, 1'b1);
    step(1'b1, 20'h0, 1'b1);
    check("R7 still invalid one slot", {9'd0, out_valid}, 10'd0);
    step(1'b0, 20'h0, 1'b1);
    step(1'b1, 20'h0, 1'b1);
    check("R2 clamp after reset chroma", word_out, 10'h000);
    check("R7 valid after refill", {9'd0, out_valid}, 10'd1);
    step(1'b0, 20'h0, 1'b1);
    check("R3 clamp after reset luma", word_out, 10'h3FF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule